// File: doc/BRIEF.md
# Read-Latency Scheduler with DLL Bypass

This block models the read-timing core of a DDR3-style memory device. On every rising clock edge it decodes a command from chip select, RAS, CAS, WE, a bank-select field and an address field. It keeps mode fields for CAS latency, CAS write latency, additive latency and DLL enable, which are written through mode-register commands. It also works out the clock cycle in which each accepted READ must launch its data burst. Each burst is eight beats long, one beat per clock. The beat values come from an internal eight-entry pattern store, indexed by the beat number.

When the DLL is bypassed, read data launches one cycle earlier than it does in normal operation. Only a CAS latency of 6 and a CAS write latency of 6 are legal in that state. A mode write that would break this rule is refused and flagged. Two countdown slots hold READs that are still waiting for their launch cycle. Each slot captures the latency that applied when its READ arrived.

The read-data output has a valid strobe and no ready input. The device timing fixes the launch cycle, so the consumer cannot apply back-pressure. Every beat with `rd_valid` high must be taken in that cycle.

Top module: `rdl_sched`

## Requirements
- R1: While reset is held and after it is released, the mode fields are DLL on, additive code 0, CL=6 and CWL=6. No burst is pending or in flight, and `rd_valid` and `cfg_err` are low. A reset asserted while a READ is pending or a burst is in flight cancels both.
- R2: The command encodings are as follows, with {cs_n, ras_n, cas_n, we_n}:
  - READ is 0101.
  - Mode write is 0000.
  - NOP is 0111. Deselect is any command with cs_n=1. Every other encoding is treated as idle.
  - An idle command starts no burst and changes no mode field. A burst already in flight or pending is not disturbed by it.
- R3: The mode-write fields are selected by `cmd_ba`:
  - `cmd_ba`=0: CL = addr[6:4]+4. Code 0 is reserved and refused.
  - `cmd_ba`=1: addr[0]=1 bypasses the DLL and addr[0]=0 enables it. addr[4:3] is the additive code: 0 gives AL=0, 1 gives AL=CL-1, 2 gives AL=CL-2, and 3 is refused.
  - `cmd_ba`=2: CWL = addr[5:3]+5.
  - Other `cmd_ba` values are ignored without error.
- R4: With the DLL on, a READ sampled at edge k drives the first beat with `rd_valid` high in the cycle that follows edge k+AL+CL.
- R5: With the DLL bypassed, that first beat follows edge k+AL+CL-1.
- R6: Some mode writes are refused and leave every mode field unchanged:
  - a write that would leave the DLL bypassed with CL≠6 or CWL≠6;
  - a write carrying a reserved code.
  - For a refused write, `cfg_err` is high for exactly the one cycle that follows the edge that sampled it.
- R7: A burst has `rd_valid` high for 8 consecutive cycles. Beat i (0..7) carries PAT_BASE + i·PAT_STEP, truncated to DATA_W bits. `rd_last` is high only on beat 7.
- R8: The latency of a READ is fixed at the edge that samples it. A later mode write does not move that READ's launch cycle.
- R9: Up to two READs may be waiting for launch at once. A READ that arrives while both slots still wait is ignored. A slot counts as waiting up to and including its launch edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_cs_n | input | 1 | Chip select, active low |
| cmd_ras_n | input | 1 | Row strobe of the command code |
| cmd_cas_n | input | 1 | Column strobe of the command code |
| cmd_we_n | input | 1 | Write enable of the command code |
| cmd_ba | input | 3 | Mode-register select for mode writes |
| cmd_addr | input | ADDR_W | Mode field value for mode writes |
| rd_valid | output | 1 | Read beat present this cycle |
| rd_data | output | DATA_W | Read beat value, zero when not valid |
| rd_last | output | 1 | Marks the eighth beat of a burst |
| cfg_err | output | 1 | One-cycle pulse after a refused mode write |

## Verification
The bench measures the launch cycle of every READ with the DLL on and with it bypassed, and under each additive-latency code. A design that forgot the one-cycle advance, or applied it in the wrong mode, would start every burst one cycle early or late. Mode writes land right after a READ, and a design that read latency at launch time instead of at the command would move those bursts. The bench also tries to leave the DLL bypassed with CL or CWL other than 6, and uses reserved codes. A design that accepted any of these would change later latencies, or fail to pulse `cfg_err`. It sends deselects that carry READ and mode-write patterns, plus a third READ while two are still pending. A design that obeyed any of these would emit a burst nobody requested.

// File: rtl/rdl_pkg.sv
package rdl_pkg;

  localparam int DLY_W = 5;

  typedef enum logic [1:0] {
    CMD_IDLE = 2'd0,
    CMD_READ = 2'd1,
    CMD_MRS  = 2'd2
  } cmd_e;

  typedef struct packed {
    logic       dll_off;
    logic [1:0] al_code;
    logic [3:0] cl;
    logic [3:0] cwl;
  } mode_t;

  localparam mode_t MODE_RESET = '{dll_off: 1'b0, al_code: 2'd0, cl: 4'd6, cwl: 4'd6};

  // cycles from the sampling edge of READ to the edge launching beat 0
  function automatic logic [DLY_W-1:0] read_delay(input mode_t m);
    logic [DLY_W-1:0] cl_v;
    logic [DLY_W-1:0] al_v;
    cl_v = DLY_W'(m.cl);
    case (m.al_code)
      2'd1:    al_v = cl_v - DLY_W'(1);
      2'd2:    al_v = cl_v - DLY_W'(2);
      default: al_v = '0;
    endcase
    return al_v + cl_v - DLY_W'(m.dll_off);
  endfunction

endpackage

// File: rtl/rdl_cmd_decode.sv
module rdl_cmd_decode
  import rdl_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    cmd = CMD_IDLE;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b101:  cmd = CMD_READ;
        3'b000:  cmd = CMD_MRS;
        default: cmd = CMD_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rdl_mode_regs.sv
module rdl_mode_regs
  import rdl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] sel,
  input  logic [6:0] field,
  output mode_t      mode,
  output logic       cfg_err
);

  mode_t      nxt;
  logic       refuse;
  logic [3:0] new_cl;
  logic [3:0] new_cwl;

  always_comb begin
    nxt     = mode;
    refuse  = 1'b0;
    new_cl  = {1'b0, field[6:4]} + 4'd4;
    new_cwl = {1'b0, field[5:3]} + 4'd5;
    case (sel)
      3'd0: begin
        refuse = (field[6:4] == 3'd0) || (mode.dll_off && new_cl != 4'd6);
        nxt.cl = new_cl;
      end
      3'd1: begin
        refuse = (field[4:3] == 2'd3) ||
                 (field[0] && (mode.cl != 4'd6 || mode.cwl != 4'd6));
        nxt.dll_off = field[0];
        nxt.al_code = field[4:3];
      end
      3'd2: begin
        refuse  = mode.dll_off && new_cwl != 4'd6;
        nxt.cwl = new_cwl;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= MODE_RESET;
      cfg_err <= 1'b0;
    end else begin
      cfg_err <= wr_en && refuse;
      if (wr_en && !refuse) mode <= nxt;
    end
  end

  p_bypass_needs_six_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode.dll_off |-> (mode.cl == 4'd6 && mode.cwl == 4'd6));

  p_refused_keeps_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $stable(mode));

endmodule

// File: rtl/rdl_slot.sv
module rdl_slot #(
  parameter int DW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] delay,
  output logic          busy,
  output logic          fire
);

  logic [DW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= delay - DW'(1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - DW'(1);
    end
  end

  assign fire = busy && (cnt == '0);

  p_load_free_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);

  p_countdown_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> (busy && cnt == $past(cnt) - DW'(1)));

endmodule

// File: rtl/rdl_burst.sv
module rdl_burst #(
  parameter int              BURST_LEN = 8,
  parameter int              DATA_W    = 16,
  parameter logic [DATA_W-1:0] PAT_BASE  = 16'hA5C0,
  parameter logic [DATA_W-1:0] PAT_STEP  = 16'h1111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              valid,
  output logic              last,
  output logic [DATA_W-1:0] data
);

  localparam int BW = $clog2(BURST_LEN);
  localparam logic [BW-1:0] LAST_BEAT = BW'(BURST_LEN - 1);

  logic [DATA_W-1:0] pat [BURST_LEN];
  logic              active;
  logic [BW-1:0]     beat;

  always_comb begin
    for (int i = 0; i < BURST_LEN; i++) begin
      pat[i] = PAT_BASE + DATA_W'(i) * PAT_STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      beat   <= '0;
    end else if (start) begin
      active <= 1'b1;
      beat   <= '0;
    end else if (active) begin
      if (beat == LAST_BEAT) active <= 1'b0;
      else                   beat   <= beat + BW'(1);
    end
  end

  assign valid = active;
  assign last  = active && (beat == LAST_BEAT);
  assign data  = active ? pat[beat] : '0;

  p_beat_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !start && beat != LAST_BEAT) |=> (active && beat == $past(beat) + BW'(1)));

  p_burst_full_length_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> ($past(beat) == LAST_BEAT));

endmodule

// File: rtl/rdl_sched.sv
module rdl_sched
  import rdl_pkg::*;
#(
  parameter int              ADDR_W    = 7,
  parameter int              DATA_W    = 16,
  parameter int              NUM_SLOTS = 2,
  parameter int              BURST_LEN = 8,
  parameter logic [DATA_W-1:0] PAT_BASE  = 16'hA5C0,
  parameter logic [DATA_W-1:0] PAT_STEP  = 16'h1111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_cs_n,
  input  logic              cmd_ras_n,
  input  logic              cmd_cas_n,
  input  logic              cmd_we_n,
  input  logic [2:0]        cmd_ba,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_last,
  output logic              cfg_err
);

  cmd_e             cmd;
  mode_t            mode;
  logic [DLY_W-1:0] delay;
  logic [NUM_SLOTS-1:0] busy;
  logic [NUM_SLOTS-1:0] fire;
  logic [NUM_SLOTS-1:0] load;
  logic [NUM_SLOTS:0]   taken;
  logic                 is_read;

  rdl_cmd_decode u_dec (
    .cs_n  (cmd_cs_n),
    .ras_n (cmd_ras_n),
    .cas_n (cmd_cas_n),
    .we_n  (cmd_we_n),
    .cmd   (cmd)
  );

  rdl_mode_regs u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cmd == CMD_MRS),
    .sel     (cmd_ba),
    .field   (cmd_addr[6:0]),
    .mode    (mode),
    .cfg_err (cfg_err)
  );

  assign delay   = read_delay(mode);
  assign is_read = (cmd == CMD_READ);
  assign taken[0] = 1'b0;

  generate
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      assign load[g]    = is_read && !busy[g] && !taken[g];
      assign taken[g+1] = taken[g] || !busy[g];
      rdl_slot #(.DW(DLY_W)) u_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load[g]),
        .delay (delay),
        .busy  (busy[g]),
        .fire  (fire[g])
      );
    end
  endgenerate

  rdl_burst #(
    .BURST_LEN (BURST_LEN),
    .DATA_W    (DATA_W),
    .PAT_BASE  (PAT_BASE),
    .PAT_STEP  (PAT_STEP)
  ) u_burst (
    .clk   (clk),
    .rst_n (rst_n),
    .start (|fire),
    .valid (rd_valid),
    .last  (rd_last),
    .data  (rd_data)
  );

  p_single_launch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fire));

  p_idle_no_new_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != CMD_READ) |=> ($countones(busy) <= $countones($past(busy))));

  p_idle_keeps_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != CMD_MRS) |=> $stable(mode));

endmodule

// File: tb/rdl_sched_tb.sv
module rdl_sched_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 16;
  localparam int BLEN = 8;
  localparam logic [15:0] PBASE = 16'hA5C0;
  localparam logic [15:0] PSTEP = 16'h1111;
  localparam int K_RD = 0, K_MRS = 1, K_NOP = 2, K_DES = 3, K_OTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [2:0] ba = '0;
  logic [6:0] addr = '0;
  logic rd_valid, rd_last, cfg_err;
  logic [DATA_W-1:0] rd_data;

  rdl_sched u_dut (
    .clk (clk), .rst_n (rst_n),
    .cmd_cs_n (cs_n), .cmd_ras_n (ras_n), .cmd_cas_n (cas_n), .cmd_we_n (we_n),
    .cmd_ba (ba), .cmd_addr (addr),
    .rd_valid (rd_valid), .rd_data (rd_data), .rd_last (rd_last), .cfg_err (cfg_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int m_cl, m_cwl, m_al;
  bit m_off;
  int st[4];
  int nst;
  int last_start;
  bit err_exp[16];
  string tag = "R1";
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  function automatic int exp_delay();
    int al;
    al = (m_al == 1) ? m_cl - 1 : (m_al == 2) ? m_cl - 2 : 0;
    return al + m_cl - (m_off ? 1 : 0);
  endfunction

  function automatic logic [15:0] pat(input int b);
    return PBASE + 16'(b) * PSTEP;
  endfunction

  function automatic int occ(input int e);
    int n = 0;
    for (int i = 0; i < nst; i++) if (st[i] >= e) n++;
    return n;
  endfunction

  function automatic void add_start(input int s);
    if (nst < 4) begin
      st[nst] = s; nst++;
    end else begin
      for (int i = 0; i < 3; i++) st[i] = st[i+1];
      st[3] = s;
    end
    last_start = s;
  endfunction

  function automatic void model_reset();
    m_cl = 6; m_cwl = 6; m_al = 0; m_off = 0;
    nst = 0; last_start = -100;
    for (int i = 0; i < 16; i++) err_exp[i] = 0;
  endfunction

  function automatic bit model_mrs(input logic [2:0] b, input logic [6:0] a);
    bit rej = 0;
    int nv;
    case (b)
      3'd0: begin
        nv = int'(a[6:4]) + 4;
        rej = (a[6:4] == 3'd0) || (m_off && nv != 6);
        if (!rej) m_cl = nv;
      end
      3'd1: begin
        rej = (a[4:3] == 2'd3) || (a[0] && (m_cl != 6 || m_cwl != 6));
        if (!rej) begin m_off = a[0]; m_al = int'(a[4:3]); end
      end
      3'd2: begin
        nv = int'(a[5:3]) + 5;
        rej = m_off && nv != 6;
        if (!rej) m_cwl = nv;
      end
      default: rej = 0;
    endcase
    return rej;
  endfunction

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic issue(input int kind, input logic [2:0] b, input logic [6:0] a);
    int e, s;
    @(posedge clk); #1;
    e = cyc + 1;
    err_exp[e % 16] = 0;
    ba = b; addr = a;
    cs_n = 1'b0; {ras_n, cas_n, we_n} = 3'b111;
    case (kind)
      K_RD: begin
        s = e + exp_delay();
        if (s >= last_start + BLEN) begin
          {ras_n, cas_n, we_n} = 3'b101;
          if (occ(e) < 2) add_start(s);
        end
      end
      K_MRS: begin
        {ras_n, cas_n, we_n} = 3'b000;
        err_exp[e % 16] = model_mrs(b, a);
      end
      K_DES: begin
        cs_n = 1'b1;
        {ras_n, cas_n, we_n} = 3'($urandom);
      end
      K_OTH: {ras_n, cas_n, we_n} = 3'b011;
      default: ;
    endcase
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) issue(K_NOP, 3'd0, 7'd0);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0;
    cs_n = 1'b1;
    model_reset();
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  always @(negedge clk) begin
    if (!done && cyc >= 1) begin
      bit ev;
      int bt;
      bit bad;
      ev = 0; bt = 0;
      for (int i = 0; i < nst; i++)
        if (st[i] <= cyc && cyc - st[i] < BLEN) begin ev = 1; bt = cyc - st[i]; end
      bad = (rd_valid !== ev) || (cfg_err !== err_exp[cyc % 16]);
      if (ev) bad = bad || (rd_data !== pat(bt)) || (rd_last !== (bt == BLEN - 1));
      n_chk++;
      if (bad) begin
        n_bad++;
        $display("FAIL %s cyc=%0d valid=%0b exp %0b data=%h exp %h last=%0b exp %0b err=%0b exp %0b",
                 tag, cyc, rd_valid, ev, rd_data, pat(bt), rd_last, (bt == BLEN - 1),
                 cfg_err, err_exp[cyc % 16]);
      end
      err_exp[cyc % 16] = 0;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired at cyc=%0d", cyc);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4021));
    model_reset();
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;

    tag = "R1 reset state and default latency";
    idle(3);
    issue(K_RD, 3'd0, 7'd0);
    idle(16);

    tag = "R3 R4 DLL on latency and field encodings";
    issue(K_MRS, 3'd0, 7'(4 << 4));          // CL=8
    idle(1);
    issue(K_RD, 3'd0, 7'd0);
    idle(18);
    issue(K_MRS, 3'd1, 7'(1 << 3));          // AL=CL-1
    issue(K_RD, 3'd0, 7'd0);
    idle(25);
    issue(K_MRS, 3'd1, 7'(2 << 3));          // AL=CL-2
    issue(K_RD, 3'd0, 7'd0);
    idle(25);
    issue(K_MRS, 3'd5, 7'h7F);               // unused select, ignored
    issue(K_RD, 3'd0, 7'd0);
    idle(25);

    tag = "R2 idle commands ignored";
    issue(K_RD, 3'd0, 7'd0);
    for (int i = 0; i < 20; i++) begin
      issue(K_DES, 3'($urandom), 7'($urandom));
      issue(K_NOP, 3'($urandom), 7'($urandom));
      issue(K_OTH, 3'($urandom), 7'($urandom));
    end
    issue(K_RD, 3'd0, 7'd0);
    idle(25);

    tag = "R5 DLL bypass latency";
    issue(K_MRS, 3'd0, 7'(2 << 4));          // CL=6
    issue(K_MRS, 3'd1, 7'd1);                // DLL off, AL=0
    issue(K_RD, 3'd0, 7'd0);
    idle(14);
    issue(K_MRS, 3'd1, 7'(1 << 3) | 7'd1);   // DLL off, AL=CL-1
    issue(K_RD, 3'd0, 7'd0);
    idle(20);

    tag = "R6 refused writes in bypass";
    issue(K_MRS, 3'd1, 7'd1);                // AL back to 0, DLL off
    issue(K_MRS, 3'd0, 7'(3 << 4));          // CL=7 refused
    issue(K_MRS, 3'd2, 7'(2 << 3));          // CWL=7 refused
    issue(K_MRS, 3'd1, 7'(3 << 3));          // reserved AL refused
    issue(K_MRS, 3'd0, 7'd0);                // reserved CL refused
    issue(K_RD, 3'd0, 7'd0);
    idle(14);
    issue(K_MRS, 3'd1, 7'd0);                // DLL on
    issue(K_MRS, 3'd0, 7'(3 << 4));          // CL=7 accepted
    issue(K_MRS, 3'd1, 7'd1);                // bypass refused, CL=7
    issue(K_RD, 3'd0, 7'd0);
    idle(16);

    tag = "R8 latency fixed at command";
    issue(K_RD, 3'd0, 7'd0);
    issue(K_MRS, 3'd0, 7'(5 << 4));          // CL=9 after READ
    issue(K_MRS, 3'd1, 7'(1 << 3));
    idle(30);

    tag = "R9 two pending reads";
    issue(K_MRS, 3'd0, 7'(7 << 4));          // CL=11
    issue(K_MRS, 3'd1, 7'(1 << 3));          // AL=10, delay 21
    issue(K_RD, 3'd0, 7'd0);
    idle(7);
    issue(K_RD, 3'd0, 7'd0);
    idle(7);
    issue(K_RD, 3'd0, 7'd0);                 // both slots waiting: ignored
    idle(45);

    tag = "R1 reset cancels pending work";
    issue(K_RD, 3'd0, 7'd0);
    idle(3);
    do_reset();
    idle(30);
    issue(K_RD, 3'd0, 7'd0);
    idle(16);

    tag = "R7 random traffic bursts";
    for (int i = 0; i < 1500; i++) begin
      int r;
      logic [6:0] a;
      r = int'($urandom % 10);
      a = 7'($urandom);
      if (r < 3) issue(K_RD, 3'd0, 7'd0);
      else if (r == 3) begin
        if ($urandom % 2 == 1) a[6:4] = 3'd2;
        if ($urandom % 2 == 1) a[5:3] = 3'd1;
        issue(K_MRS, 3'($urandom % 4), a);
      end
      else if (r == 4) issue(K_DES, 3'($urandom), a);
      else if (r == 5) issue(K_OTH, 3'($urandom), a);
      else issue(K_NOP, 3'd0, a);
    end
    idle(40);
    finish_run();
  end

endmodule